// File: doc/BRIEF.md
# Quadword ECC Memory Path with Hardware Scrub

This block protects a small on-chip word store with a single-error-correcting, double-error-detecting code. The host side issues reads and writes of 64-bit quadwords over a valid/ready request port, with one byte-enable bit per byte lane. Each stored word is 72 bits wide: 64 data bits in bits 63:0 and 8 check bits in bits 71:64. The check bits are a Hamming code over the data plus one overall parity bit.

A two-bit mode input sets the protection level. It can turn checking off, report errors without touching the data, correct single-bit errors, or correct them and also write the repaired word back into the store. Writes that cover only part of a quadword are done as a read-modify-write inside the block, so the check bits always cover the full merged word. Every read and every read-modify-write drives one-cycle single-bit and multi-bit error pulses together with the quadword address of the failing access.

A fault-injection port flips chosen stored bits. It lets the surrounding system or a bench place known errors in the store.

Top module: `ecc_scrub_mem`

## Requirements
- R1: A read accepted on clock edge k drives rsp_valid high for exactly the one cycle after edge k+1, with the stored data on rsp_rdata. A word written in a checking mode reads back equal to what was written, with no error flag.
- R2: req_ready is high after reset. It is low in the cycle after a request is accepted, so at most one request is in flight.
- R3: A write whose byte enables are not all set replaces only the enabled byte lanes (enable bit i covers data bits 8i+7:8i) and keeps the other lanes. A later read of that word shows no error.
- R4: Mode 2'b00 turns checking off. Writes store all-zero check bits, and reads return the raw stored data without raising err_sbe or err_mbe. When such a word holds nonzero data and is later read in mode 2'b10, an error is flagged.
- R5: Mode 2'b01 detects only. Single-bit and multi-bit errors are flagged, the returned data is the raw stored data, and the store is left unchanged.
- R6: Mode 2'b10 corrects. A single-bit error is flagged on err_sbe and the corrected data is returned, but the stored word is not rewritten.
- R7: Mode 2'b11 corrects and scrubs. A read that corrects a single-bit error writes the corrected word back and holds req_ready low for one extra cycle. A later read of that word is clean, and a second single-bit fault in it is still correctable.
- R8: A double-bit error raises err_mbe, returns the raw data, and is never written back in any mode, so a re-read reports it again.
- R9: A single flipped check bit (stored bits 71:64) is reported on err_sbe, and the returned data is intact.
- R10: err_sbe and err_mbe are never high together. Each is a one-cycle pulse, and err_addr carries the quadword address of the access that raised it.
- R11: An inj_en pulse XORs inj_mask into the stored 72-bit word at inj_addr, using the layout {check[7:0], data[63:0]}.
- R12: A partial write to a word whose old contents hold an error the current mode cannot correct raises the error flag and leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the store |
| mode | input | 2 | Protection mode, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Quadword address (ADDR_W = log2 DEPTH) |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for writes |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 64 | Read data |
| err_sbe | output | 1 | Single-bit error pulse |
| err_mbe | output | 1 | Multi-bit error pulse |
| err_addr | output | ADDR_W | Address of the flagged access |
| inj_en | input | 1 | Apply fault mask this cycle |
| inj_addr | input | ADDR_W | Word targeted by the fault mask |
| inj_mask | input | 72 | Bits of the stored word to flip |

## Verification
The bench places one-bit and two-bit faults in data and check positions. In each mode it then compares the returned data and flags against what that mode promises. A scrub that never wrote back would fail the test where a second fault is injected into a word that was already scrubbed: that test expects a correction and would see a multi-bit report instead. A design that scrubbed in correct-only mode or on double errors would fail the repeated reads, which expect the same error to be reported again. Partial writes are checked for lane merging, for fresh check bits, and for refusing to merge over an uncorrectable word. A random mix of full and partial writes and reads in the three checking modes is compared against a byte-lane model of the store.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;
    localparam int DW = 64;
    localparam int CW = 8;
    localparam int WW = DW + CW;
    localparam int HB = CW - 1;
    localparam int NBYTE = DW / 8;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_DETECT  = 2'b01,
        MODE_CORRECT = 2'b10,
        MODE_SCRUB   = 2'b11
    } ecc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LOOK  = 2'b01,
        ST_SCRUB = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          sbe;
        logic          mbe;
    } dec_res_t;

    // Hamming slot of data bit d: the d-th position that is not a power of two
    function automatic logic [HB-1:0] bit_slot(input int d);
        int cnt;
        logic [HB-1:0] res;
        cnt = 0;
        res = '0;
        for (int p = 3; p < (1 << HB); p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == d) res = HB'(p);
                cnt++;
            end
        end
        return res;
    endfunction

    function automatic logic [CW-1:0] make_check(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        logic [HB-1:0] s;
        c = '0;
        for (int dd = 0; dd < DW; dd++) begin
            s = bit_slot(dd);
            for (int i = 0; i < HB; i++)
                if (s[i]) c[i] = c[i] ^ d[dd];
        end
        c[CW-1] = (^d) ^ (^c[HB-1:0]);
        return c;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_scrub_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic          off,
    output logic [CW-1:0] check
);
    always_comb check = off ? '0 : make_check(data);
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import ecc_scrub_pkg::*;
(
    input  logic [WW-1:0] word,
    output dec_res_t      res
);
    logic [CW-1:0] fresh;
    logic [HB-1:0] syn;
    logic          par;

    always_comb begin
        fresh = make_check(word[DW-1:0]);
        syn   = word[DW +: HB] ^ fresh[HB-1:0];
        par   = ^word;
        res.data = word[DW-1:0];
        res.sbe  = 1'b0;
        res.mbe  = 1'b0;
        if (par) begin
            if (int'(syn) > WW - 1) begin
                res.mbe = 1'b1;
            end else begin
                res.sbe = 1'b1;
                for (int d = 0; d < DW; d++)
                    if (bit_slot(d) == syn) res.data[d] = ~word[d];
            end
        end else if (syn != '0) begin
            res.mbe = 1'b1;
        end
    end
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
    import ecc_scrub_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [WW-1:0] wr_word,
    input  logic          inj_en,
    input  logic [AW-1:0] inj_addr,
    input  logic [WW-1:0] inj_mask,
    input  logic [AW-1:0] rd_addr,
    output logic [WW-1:0] rd_word
);
    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
            if (wr_en)  mem[wr_addr]  <= wr_word;
        end
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem
    import ecc_scrub_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [7:0]        req_be,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              err_sbe,
    output logic              err_mbe,
    output logic [ADDR_W-1:0] err_addr,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [71:0]       inj_mask
);
    seq_state_e        state;
    ecc_mode_e         r_mode;
    logic              r_write;
    logic [ADDR_W-1:0] r_addr;
    logic [DW-1:0]     r_wdata;
    logic [NBYTE-1:0]  r_be;
    logic [DW-1:0]     r_fix;

    logic [WW-1:0] rd_word, wr_word;
    dec_res_t      dec;
    logic [DW-1:0] base, merged, wr_data;
    logic [CW-1:0] wr_check;
    logic          flag_sbe, flag_mbe, can_write, wr_en;

    ecc_word_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(r_addr), .wr_word(wr_word),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
        .rd_addr(r_addr), .rd_word(rd_word)
    );

    ecc_decoder u_dec (.word(rd_word), .res(dec));

    ecc_encoder u_enc (.data(wr_data), .off(r_mode == MODE_OFF), .check(wr_check));

    always_comb begin
        flag_sbe  = (r_mode != MODE_OFF) && dec.sbe;
        flag_mbe  = (r_mode != MODE_OFF) && dec.mbe;
        base      = r_mode[1] ? dec.data : rd_word[DW-1:0];
        can_write = !flag_mbe && !(r_mode == MODE_DETECT && flag_sbe);
        for (int b = 0; b < NBYTE; b++)
            merged[8*b +: 8] = r_be[b] ? r_wdata[8*b +: 8] : base[8*b +: 8];
        wr_data = (state == ST_SCRUB) ? r_fix : merged;
        wr_word = {wr_check, wr_data};
        wr_en   = (state == ST_SCRUB) ||
                  (state == ST_LOOK && r_write && ((&r_be) || can_write));
    end

    assign req_ready = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            r_mode    <= MODE_OFF;
            r_write   <= 1'b0;
            r_addr    <= '0;
            r_wdata   <= '0;
            r_be      <= '0;
            r_fix     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            err_sbe   <= 1'b0;
            err_mbe   <= 1'b0;
            err_addr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            err_sbe   <= 1'b0;
            err_mbe   <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    r_mode  <= ecc_mode_e'(mode);
                    r_write <= req_write;
                    r_addr  <= req_addr;
                    r_wdata <= req_wdata;
                    r_be    <= req_write ? req_be : '0;
                    state   <= ST_LOOK;
                end
                ST_LOOK: begin
                    // full writes overwrite blindly; everything else reports
                    if (!(r_write && (&r_be))) begin
                        err_sbe  <= flag_sbe;
                        err_mbe  <= flag_mbe;
                        err_addr <= r_addr;
                    end
                    if (!r_write) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= base;
                    end
                    if (!r_write && r_mode == MODE_SCRUB && flag_sbe) begin
                        r_fix <= dec.data;
                        state <= ST_SCRUB;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ecc_scrub_mem_chk.sv
module ecc_scrub_mem_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       err_sbe,
    input logic       err_mbe
);
    p_flag_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(err_sbe && err_mbe));

    p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (err_sbe || err_mbe) |-> $past(mode, 2) != 2'b00);

    p_scrub_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && err_sbe && $past(mode, 2) == 2'b11) |-> !req_ready);

    p_no_mbe_fix_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && err_mbe) |-> req_ready);
endmodule

bind ecc_scrub_mem ecc_scrub_mem_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid),
    .req_ready(req_ready), .rsp_valid(rsp_valid),
    .err_sbe(err_sbe), .err_mbe(err_mbe)
);

// File: tb/ecc_scrub_mem_test.sv
`timescale 1ns/1ps
module ecc_scrub_mem_test;
    localparam int DEPTH = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b10;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic [7:0]    req_be = '0;
    logic          rsp_valid, err_sbe, err_mbe;
    logic [63:0]   rsp_rdata;
    logic [AW-1:0] err_addr;
    logic          inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [71:0]   inj_mask = '0;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [63:0] model [DEPTH];

    always #2 clk = ~clk;

    ecc_scrub_mem #(.DEPTH(DEPTH)) uut (.*);

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    logic [63:0] q; logic s, m, rv, rdy; logic [AW-1:0] ea;

    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        q = rsp_rdata; s = err_sbe; m = err_mbe; ea = err_addr; rv = rsp_valid; rdy = req_ready;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        xfer(1'b0, a, '0, '0);
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [71:0] msk);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_mask = msk;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    initial begin
        logic [63:0] d1, d2, mg, d3, d4, d5;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 ready after reset", req_ready, 1);
        check("R10 no flags after reset", {err_sbe, err_mbe, rsp_valid}, 3'b000);

        // R1 roundtrip
        mode = 2'b10; d1 = 64'h0123_4567_89ab_cdef;
        xfer(1, 3, d1, 8'hff);
        rd(3);
        check("R1 read data", q, d1);
        check("R1 rsp flags", {rv, s, m}, 3'b100);
        check("R2 ready back", rdy, 1);

        // R3 partial write
        d2 = 64'hffee_ddcc_bbaa_9988;
        xfer(1, 3, d2, 8'h0f);
        mg = merge(d1, d2, 8'h0f);
        rd(3);
        check("R3 merged data", q, mg);
        check("R3 clean after rmw", {s, m}, 2'b00);

        // R11/R6 single flip, correct mode
        inject(3, 72'd1 << 17);
        rd(3);
        check("R6 corrected", q, mg);
        check("R6 sbe", {s, m}, 2'b10);
        check("R10 err addr", ea, 3);
        rd(3);
        check("R6 no writeback", {s, m}, 2'b10);

        // R5 detect only
        mode = 2'b01;
        rd(3);
        check("R5 raw data", q, mg ^ (64'd1 << 17));
        check("R5 sbe", {s, m}, 2'b10);
        rd(3);
        check("R5 unchanged", {q, s}, {mg ^ (64'd1 << 17), 1'b1});

        // R7 scrub
        mode = 2'b11;
        rd(3);
        check("R7 corrected", q, mg);
        check("R7 sbe", {s, m}, 2'b10);
        check("R7 ready held", rdy, 0);
        rd(3);
        check("R7 clean after scrub", {q, s, m}, {mg, 2'b00});
        mode = 2'b10;
        inject(3, 72'd1 << 40);
        rd(3);
        check("R7 second fault correctable", {q, s, m}, {mg, 2'b10});
        mode = 2'b11;
        rd(3);

        // R8 double error
        mode = 2'b10; d3 = 64'h5a5a_1234_dead_beef;
        xfer(1, 5, d3, 8'hff);
        inject(5, (72'd1 << 2) | (72'd1 << 60));
        d3 = d3 ^ (64'd1 << 2) ^ (64'd1 << 60);
        rd(5);
        check("R8 mbe raw", {q, s, m}, {d3, 2'b01});
        check("R10 mbe addr", ea, 5);
        mode = 2'b11;
        rd(5);
        check("R8 no scrub", {m, rdy}, 2'b11);
        rd(5);
        check("R8 still mbe", {q, m}, {d3, 1'b1});
        mode = 2'b01;
        rd(5);
        check("R5 mbe detect", {s, m}, 2'b01);

        // R12 rmw on uncorrectable word
        mode = 2'b10;
        xfer(1, 5, 64'hff, 8'h01);
        check("R12 rmw flags", {m, ea}, {1'b1, 4'd5});
        rd(5);
        check("R12 word kept", {q, m}, {d3, 1'b1});

        // R9 check bit flip
        d4 = 64'hcafe_f00d_0bad_c0de;
        xfer(1, 7, d4, 8'hff);
        inject(7, 72'd1 << 66);
        rd(7);
        check("R9 check bit sbe", {q, s, m}, {d4, 2'b10});

        // R4 off mode
        mode = 2'b00; d5 = 64'h0000_ffff_0f0f_7777;
        xfer(1, 9, d5, 8'hff);
        rd(9);
        check("R4 off read", {q, s, m}, {d5, 2'b00});
        inject(9, 72'd1);
        rd(9);
        check("R4 off ignores fault", {q, s, m}, {d5 ^ 64'd1, 2'b00});
        mode = 2'b10;
        rd(9);
        check("R4 zero check flagged", s | m, 1);

        // random phase
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = {$urandom, $urandom};
            xfer(1, AW'(a), model[a], 8'hff);
        end
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] a; logic [63:0] d; logic [7:0] be;
            mode = 2'($urandom_range(1, 3));
            a = AW'($urandom_range(0, DEPTH - 1));
            d = {$urandom, $urandom};
            be = ($urandom_range(0, 2) == 0) ? 8'hff : 8'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                xfer(1, a, d, be);
                model[a] = merge(model[a], d, be);
            end else begin
                rd(a);
                check("R1 random read", {q, s, m}, {model[a], 2'b00});
                check("R3 random rsp", rv, 1);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule